// File: doc/BRIEF.md
# Strobed Latch 4-to-16 Decoder

This block keeps a small binary address in a strobe-gated register and turns it into a set of active-low select lines. It is built for address decoding that only follows the address bus while a strobe is high. When the strobe drops, the selection stays frozen, even if the bus moves on to other values.

Strobe and data are sampled on the rising edge of a system clock. In every cycle where the strobe is sampled high, the register loads the data. In every cycle where it is sampled low, the register keeps its value. So the value held after a falling strobe is the data present in the last cycle with the strobe high. The register drives a one-hot decode, and the outputs are the inverse of that decode: one-cold. A separate inhibit input forces every output high at once, with no clock involved. Inhibit does not change the stored address. A synchronous reset sets the stored address to zero.

Top module: `strobe_decoder`

## Requirements
- R1: At a rising clock edge where `strobe` is sampled high, the stored address takes the value of `data`. From that edge on, `sel_n` shows the decode of that value.
- R2: At a rising clock edge where `strobe` is sampled low, the stored address does not change. Changes on `data` while the strobe stays low have no effect on `sel_n`.
- R3: After the strobe falls, the held selection is the `data` value from the last clock edge at which `strobe` was sampled high.
- R4: While `inhibit` is 1, every bit of `sel_n` is 1, whatever `strobe` and `data` are. This applies with no clock latency.
- R5: `inhibit` does not stop the stored address from loading or holding. When `inhibit` returns to 0, `sel_n` shows the decode of the address the register holds at that time.
- R6: While `inhibit` is 0, exactly one bit of `sel_n` is 0. For address n, that bit is `sel_n[n]`, where n = data[0] + 2*data[1] + 4*data[2] + 8*data[3] (data[0] is the least significant bit).
- R7: A clock edge with `rst` high sets the stored address to 0. With `inhibit` at 0, `sel_n` then reads 16'hFFFE.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock; strobe and data are sampled on its rising edge |
| rst | input | 1 | Synchronous active-high reset of the stored address |
| strobe | input | 1 | 1: register follows data; 0: register holds |
| data | input | ADDR_W (4) | Binary address in, bit 0 least significant |
| inhibit | input | 1 | 1 drives all select lines high |
| sel_n | output | 2**ADDR_W (16) | One-cold select lines |

## Verification
The assertions check four things on every cycle:
- With inhibit low, exactly one line is low.
- With inhibit high, all lines are high.
- A cycle with the strobe high loads the address sampled at that edge.
- A cycle with the strobe low leaves the visible selection unchanged.

Some behaviours only the bench's scenarios can show:
- Which line belongs to each of the sixteen addresses.
- That the value held after a falling strobe is the last value loaded.
- That an address loaded or held while the outputs were inhibited reappears when inhibit is released.

// File: rtl/strobe_decoder.sv
module strobe_decoder #(
  parameter int ADDR_W = 4,
  localparam int OUT_N = 1 << ADDR_W
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              strobe,
  input  logic [ADDR_W-1:0] data,
  input  logic              inhibit,
  output logic [OUT_N-1:0]  sel_n
);

  logic [ADDR_W-1:0] addr_q;
  logic [OUT_N-1:0]  onehot;

  always_ff @(posedge clk) begin
    if (rst)         addr_q <= '0;
    else if (strobe) addr_q <= data;
  end

  always_comb begin
    onehot = '0;
    onehot[addr_q] = 1'b1;
  end

  assign sel_n = inhibit ? '1 : ~onehot;

  a_r1_load: assert property (@(posedge clk) disable iff (rst)
    strobe |=> (inhibit || sel_n == ~(OUT_N'(1) << $past(data))));

  a_r2_hold: assert property (@(posedge clk) disable iff (rst)
    (!strobe && !inhibit) |=> (inhibit || $stable(sel_n)));

  a_r4_inhibit: assert property (@(posedge clk) inhibit |-> (&sel_n));

  a_r6_onecold: assert property (@(posedge clk) disable iff (rst)
    !inhibit |-> ($countones(~sel_n) == 1));

  a_r7_reset: assert property (@(posedge clk)
    rst |=> (inhibit || sel_n == ~OUT_N'(1)));

endmodule

// File: tb/strobe_decoder_tb.sv
module strobe_decoder_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        strobe = 1'b0;
  logic [3:0]  data = '0;
  logic        inhibit = 1'b0;
  logic [15:0] sel_n;
  int          n_run = 0;
  int          n_fail = 0;
  bit          done = 1'b0;

  strobe_decoder #(.ADDR_W(4)) u_dut (
    .clk(clk), .rst(rst), .strobe(strobe), .data(data),
    .inhibit(inhibit), .sel_n(sel_n)
  );

  always #10 clk = ~clk;

  function automatic logic [15:0] dec(input int n);
    return ~(16'd1 << n);
  endfunction

  task automatic chk(input logic [15:0] exp, input string req);
    n_run++;
    if (sel_n !== exp) begin
      n_fail++;
      $display("FAIL %s: sel_n=%h expected %h", req, sel_n, exp);
    end
  endtask

  task automatic cyc();
    @(negedge clk);
  endtask

  initial begin
    #4000000;
    if (!done) begin
      n_run++;
      n_fail++;
      $display("FAIL watchdog: run hung, got 0 expected 1");
      $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
      $finish;
    end
  end

  initial begin
    cyc(); data = 4'd7;
    cyc(); chk(16'hFFFE, "R7 reset address 0");
    rst = 1'b0;

    strobe = 1'b1;
    for (int n = 0; n < 16; n++) begin
      data = n[3:0];
      cyc(); chk(dec(n), "R1/R6 transparent sweep");
    end

    data = 4'd9; cyc(); chk(dec(9), "R1 load 9");
    strobe = 1'b0; data = 4'd3;
    cyc(); chk(dec(9), "R3 held after fall");
    for (int n = 0; n < 16; n++) begin
      data = n[3:0];
      cyc(); chk(dec(9), "R2 hold while strobe low");
    end

    strobe = 1'b1; data = 4'd12; cyc();
    strobe = 1'b0; data = 4'd1; cyc();
    chk(dec(12), "R3 last high-strobe value");

    inhibit = 1'b1; #1 chk(16'hFFFF, "R4 inhibit, strobe low");
    strobe = 1'b1; data = 4'd5; cyc();
    chk(16'hFFFF, "R4 inhibit, strobe high");
    strobe = 1'b0; data = 4'd14; cyc();
    chk(16'hFFFF, "R4 inhibit, strobe low again");
    inhibit = 1'b0; #1 chk(dec(5), "R5 load under inhibit reappears");

    inhibit = 1'b1; data = 4'd2; cyc(); cyc();
    inhibit = 1'b0; #1 chk(dec(5), "R5 hold under inhibit reappears");

    strobe = 1'b1; data = 4'd15; cyc(); chk(dec(15), "R6 top address");
    rst = 1'b1; cyc(); chk(16'hFFFE, "R7 reset mid-run");
    rst = 1'b0;

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
    $finish;
  end
endmodule